// File: doc/BRIEF.md
# Interrupt Enable and Status Bank

This block gathers 64 already-conditioned interrupt lines into two 32-line words, low and high. Each line can also be raised by software through a pending bit. Every line has an enable bit. The block drives one interrupt request to a parent controller whenever an enabled line is active.

Software reaches the block through a simple word-wide register port. Writes are synchronous and reads are combinational. Enable bits and software-pending bits are never written directly. Each has a pair of write-one registers: one sets bits, the other clears them. Zero bits in the written word leave the state as it was. The high word's registers repeat the low word's layout, shifted up by 0x18.

Several such banks can share one trigger-conditioning stage upstream. This project holds a single bank. The bank's base address is decoded outside it, so `reg_addr` is the byte offset within the bank.

Top module: `irq_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every enable bit and every software-pending bit is zero. So `irq_out` is 0, and reads at offsets 0x00, 0x08, 0x10 and 0x18 return 0 when no software bits have been set.
- R2: A write to the enable-set offset (0x08 for the low word, 0x20 for the high word) sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R3: A write to the enable-clear offset (0x0C for the low word, 0x24 for the high word) clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Writing 0xFFFFFFFF disables the whole word.
- R4: The software-pending bits follow the same write-one rule as the enables. Set is at offset 0x10 (low) and 0x28 (high). Clear is at offset 0x14 (low) and 0x2C (high).
- R5: Reading the raw status at offset 0x04 (low) or 0x1C (high) returns, for each line, the OR of its input line and its software-pending bit.
- R6: Reading the masked status at offset 0x00 (low) or 0x18 (high) returns the raw status ANDed with the enable bits.
- R7: `irq_out` is 1 exactly when any masked-status bit of either word is 1. It follows the inputs combinationally.
- R8: The low word's registers act only on lines 0 to 31, and the high word's registers act only on lines 32 to 63.
- R9: Reading a set or clear offset returns the current state word it controls: enables at 0x08/0x0C (and 0x20/0x24), pending bits at 0x10/0x14 (and 0x28/0x2C).
- R10: Writes to the status offsets, to offsets 0x30 and above, or to offsets whose two low bits are not zero change no state. Reads of offsets 0x30 and above, or of offsets whose two low bits are not zero, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Conditioned interrupt lines; bit n is line n |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 6 | Byte offset within the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Request to the parent controller |

## Verification
The bench sets and clears enables with patterns that overlap the state already held. A design that overwrote the word instead of ORing or ANDing into it would lose bits that the write did not target.

It drives a line high in one word while programming the other word. A stride error would then show up as a status or enable bit moving in the wrong word.

It writes to the read-only status offsets, to offsets past the end of the map, and to misaligned offsets. A loose decoder would corrupt the enables or pending bits on those writes.

It removes the last enabled source in several ways: by dropping the line, by clearing the enable, and by clearing the pending bit. A design whose request output lagged or stuck would be caught there.

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int LINES  = 64,
  parameter int GRP_W  = 32,
  parameter int ADDR_W = 6,
  parameter int HI_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GRP_W-1:0]  reg_wdata,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic              irq_out
);
  localparam int NGRP  = LINES / GRP_W;
  localparam int MAP_END = NGRP * HI_OFS;

  localparam logic [2:0] SEL_MSK  = 3'd0;
  localparam logic [2:0] SEL_RAW  = 3'd1;
  localparam logic [2:0] SEL_ESET = 3'd2;
  localparam logic [2:0] SEL_ECLR = 3'd3;
  localparam logic [2:0] SEL_SSET = 3'd4;
  localparam logic [2:0] SEL_SCLR = 3'd5;

  logic [LINES-1:0] en_all, soft_all, raw_all, msk_all;

  logic              in_map;
  logic              grp_hi;
  logic [ADDR_W-1:0] grp_off;
  logic [2:0]        sel;

  assign in_map  = (int'(reg_addr) < MAP_END) && (reg_addr[1:0] == 2'b00);
  assign grp_hi  = int'(reg_addr) >= HI_OFS;
  assign grp_off = grp_hi ? reg_addr - ADDR_W'(HI_OFS) : reg_addr;
  assign sel     = grp_off[4:2];

  assign raw_all = irq_lines | soft_all;
  assign msk_all = raw_all & en_all;
  assign irq_out = |msk_all;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] en_w, soft_w;
    logic             hit;

    assign hit = reg_wr && in_map && (grp_hi == (g != 0));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_w   <= '0;
        soft_w <= '0;
      end else if (hit) begin
        case (sel)
          SEL_ESET: en_w   <= en_w | reg_wdata;
          SEL_ECLR: en_w   <= en_w & ~reg_wdata;
          SEL_SSET: soft_w <= soft_w | reg_wdata;
          SEL_SCLR: soft_w <= soft_w & ~reg_wdata;
          default: ;
        endcase
      end
    end

    assign en_all[g*GRP_W +: GRP_W]   = en_w;
    assign soft_all[g*GRP_W +: GRP_W] = soft_w;
  end

  logic [GRP_W-1:0] w_msk, w_raw, w_en, w_soft;

  assign w_msk  = grp_hi ? msk_all[2*GRP_W-1:GRP_W]  : msk_all[GRP_W-1:0];
  assign w_raw  = grp_hi ? raw_all[2*GRP_W-1:GRP_W]  : raw_all[GRP_W-1:0];
  assign w_en   = grp_hi ? en_all[2*GRP_W-1:GRP_W]   : en_all[GRP_W-1:0];
  assign w_soft = grp_hi ? soft_all[2*GRP_W-1:GRP_W] : soft_all[GRP_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (in_map) begin
      case (sel)
        SEL_MSK:            reg_rdata = w_msk;
        SEL_RAW:            reg_rdata = w_raw;
        SEL_ESET, SEL_ECLR: reg_rdata = w_en;
        SEL_SSET, SEL_SCLR: reg_rdata = w_soft;
        default:            reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int LINES  = 64,
  parameter int GRP_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [GRP_W-1:0]  reg_wdata,
  input logic              irq_out,
  input logic [LINES-1:0]  en_q,
  input logic [LINES-1:0]  soft_q
);
  logic bad_addr;
  assign bad_addr = (reg_addr >= ADDR_W'('h30)) || (reg_addr[1:0] != 2'b00) ||
                    (reg_addr == ADDR_W'('h00)) || (reg_addr == ADDR_W'('h04)) ||
                    (reg_addr == ADDR_W'('h18)) || (reg_addr == ADDR_W'('h1C));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0) && (soft_q == '0));

  assert_en_set_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'('h08) |=>
      (en_q[GRP_W-1:0] & $past(reg_wdata)) == $past(reg_wdata));

  assert_en_clr_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'('h24) |=>
      (en_q[LINES-1:GRP_W] & $past(reg_wdata)) == '0);

  assert_soft_clr_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'('h2C) |=>
      (soft_q[LINES-1:GRP_W] & $past(reg_wdata)) == '0);

  assert_no_enable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

  assert_low_write_keeps_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr < ADDR_W'('h18) |=>
      $stable(en_q[LINES-1:GRP_W]) && $stable(soft_q[LINES-1:GRP_W]));

  assert_bad_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && bad_addr |=> $stable(en_q) && $stable(soft_q));
endmodule

bind irq_bank irq_bank_chk #(.LINES(LINES), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .en_q(en_all), .soft_q(soft_all)
);

// File: tb/sim_irq_bank.sv
`timescale 1ns/1ps
module sim_irq_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_lines = '0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int total = 0, bad = 0;

  irq_bank u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); chk("R1 low masked", d, 0);
    rd(6'h08, d); chk("R1 low enables", d, 0);
    rd(6'h10, d); chk("R1 low soft", d, 0);
    rd(6'h18, d); chk("R1 high masked", d, 0);
    chk("R1 irq_out", {31'd0, irq_out}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(6'h08, 32'h0000_00F0);
    wr(6'h08, 32'h0000_0F00);
    rd(6'h08, d); chk("R2 set accumulates", d, 32'h0000_0FF0);
    wr(6'h0C, 32'h0000_0330);
    rd(6'h0C, d); chk("R3 partial clear / R9 readback", d, 32'h0000_0CC0);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    irq_lines[3:0] = 4'b0101;
    wr(6'h10, 32'h0000_0002);
    rd(6'h04, d); chk("R5 raw low", d, 32'h0000_0007);
    rd(6'h14, d); chk("R9 soft readback", d, 32'h0000_0002);
    chk("R7 no enables idle", {31'd0, irq_out}, 0);
    wr(6'h08, 32'h0000_000A);
    rd(6'h00, d); chk("R6 masked low", d, 32'h0000_0002);
    chk("R7 soft drives out", {31'd0, irq_out}, 1);
    wr(6'h14, 32'h0000_0002);
    rd(6'h00, d); chk("R4 soft clear", d, 0);
    chk("R7 drops after soft clear", {31'd0, irq_out}, 0);
    irq_lines[3] = 1;
    #1 chk("R7 line raises out", {31'd0, irq_out}, 1);
    irq_lines[3] = 0;
    #1 chk("R7 line drop lowers out", {31'd0, irq_out}, 0);
    wr(6'h0C, 32'hFFFF_FFFF);
    irq_lines = '0;
  endtask

  task automatic t_high;
    logic [31:0] d;
    irq_lines[40] = 1;
    wr(6'h20, 32'h0000_0100);
    rd(6'h18, d); chk("R8 high masked", d, 32'h0000_0100);
    rd(6'h00, d); chk("R8 low untouched", d, 0);
    rd(6'h08, d); chk("R8 low enables untouched", d, 0);
    chk("R7 high word drives out", {31'd0, irq_out}, 1);
    wr(6'h28, 32'h8000_0000);
    rd(6'h1C, d); chk("R5 raw high", d, 32'h8000_0100);
    rd(6'h04, d); chk("R8 low raw untouched", d, 0);
    wr(6'h2C, 32'h8000_0000);
    rd(6'h28, d); chk("R4 high soft clear", d, 0);
    wr(6'h24, 32'h0000_0100);
    chk("R7 high enable cleared", {31'd0, irq_out}, 0);
    irq_lines = '0;
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(6'h08, 32'h0000_0011);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h09, 32'hFFFF_FFFF);
    wr(6'h0D, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R10 low enables kept", d, 32'h0000_0011);
    rd(6'h20, d); chk("R10 high enables kept", d, 0);
    rd(6'h10, d); chk("R10 low soft kept", d, 0);
    rd(6'h28, d); chk("R10 high soft kept", d, 0);
    rd(6'h30, d); chk("R10 unmapped read", d, 0);
    rd(6'h09, d); chk("R10 misaligned read", d, 0);
  endtask

  task automatic t_reset_again;
    logic [31:0] d;
    wr(6'h10, 32'h0000_0001);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(6'h08, d); chk("R1 reset clears enables", d, 0);
    rd(6'h10, d); chk("R1 reset clears soft", d, 0);
    chk("R1 out after reset", {31'd0, irq_out}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enable();
        t_status();
        t_high();
        t_ignored();
        t_reset_again();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule